// File: doc/BRIEF.md
# External Clock Frequency and Duty Watchdog

This block watches a slow control clock that arrives from outside the chip. Its nominal rate is 250 kHz. The block samples that clock with a faster internal reference clock, nominally 8 MHz. It declares the clock bad in three cases: the clock runs too slowly, it stops toggling, or its high time leaves the 45 % to 55 % window for a full period. The verdict goes to a downstream fault latch, which forces every channel status to its error state and turns the power outputs off. A second flag disables the current regulators whenever the clock has fallen below the minimum frequency. A third output tells whether the clock is currently toggling within the allowed period.

The external clock first passes through a synchronizer. High time and low time are then counted in reference cycles, and each complete period is judged at its closing rising edge. The judgement uses only multiply-and-compare, with no divider. After a failure, both flags stay set until the clock is present again, which means two consecutive good periods in a row.

Top module: `extclk_watchdog`

## Requirements
- R1: While reset is applied and just after it, `clkFail` = 1, `regOff` = 1 and `clkPresent` = 0.
- R2: The external clock passes through a two-flop synchronizer. With H high cycles and L low cycles of the reference clock, and P = H + L, a period is good exactly when P ≤ 80 and 9·P ≤ 20·H ≤ 11·P (both bounds inclusive).
- R3: A judged period of at most 80 cycles with 20·H < 9·P sets `clkFail`, and leaves `regOff` unchanged.
- R4: A judged period of at most 80 cycles with 20·H > 11·P sets `clkFail`, and leaves `regOff` unchanged.
- R5: A completed period with P > 80 (a clock below the minimum frequency) sets both `clkFail` and `regOff`.
- R6: When more than 80 reference cycles pass without a rising edge, `clkFail` and `regOff` are set and `clkPresent` drops to 0, without waiting for any further edge.
- R7: Once set, `clkFail` and `regOff` clear together only after two consecutive judged good periods. Any bad period or stall restarts that count. The interval closed by the first rising edge after reset is never judged.
- R8: `clkPresent` is 1 from the first rising edge after reset for as long as fewer than 81 reference cycles have passed since the last rising edge.
- R9: The high-time and low-time counters saturate instead of wrapping, so a clock stuck for hundreds of cycles keeps `clkPresent` = 0 and the flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running internal reference clock (nominally 8 MHz) |
| rstN | input | 1 | Asynchronous reset, active low |
| extClk | input | 1 | Supervised external clock, asynchronous to refClk |
| clkFail | output | 1 | Clock failure flag for the fault latch |
| regOff | output | 1 | Regulator disable, set on frequency loss |
| clkPresent | output | 1 | External clock currently toggling within the period limit |

## Verification
A corrupted high-time or low-time count shows up at the next rising edge of the external clock. It appears as a good period reported as a duty or frequency failure, or the reverse, with roughly a four-cycle synchronizer and register delay. A wrong consecutive-good count shows when `clkFail` clears one period too early or too late after a recovery sequence. A counter that wraps only shows during long stalls, where `clkPresent` would return to 1 with no edge arriving.

// File: rtl/clkw_pkg.sv
package clkw_pkg;

  // Strobes from the control to the datapath, one set per reference cycle.
  typedef struct packed {
    logic rise;   // synchronized clock has just gone high
    logic fall;   // synchronized clock has just gone low
    logic high;   // synchronized clock level
  } edgeStrobe_t;

  // Measurement results returned by the datapath.
  typedef struct packed {
    logic done;     // a period closes this cycle
    logic dutyOk;   // high time of the closing period within window
    logic overrun;  // elapsed time since last rise beyond limit
  } verdict_t;

endpackage

// File: rtl/clkw_sync.sv
module clkw_sync #(
  parameter int STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/clkw_datapath.sv
module clkw_datapath
  import clkw_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MAX_PERIOD = 80,
  parameter int DUTY_SCALE = 20,
  parameter int LO_NUM     = 9,
  parameter int HI_NUM     = 11
) (
  input  logic        refClk,
  input  logic        rstN,
  input  edgeStrobe_t strobe,
  output verdict_t    verdict
);

  localparam int SUM_W  = CNT_W + 1;
  localparam int MUL_W  = $clog2(DUTY_SCALE + HI_NUM + 1);
  localparam int PROD_W = SUM_W + MUL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SUM_W-1:0] LEN_LIMIT = SUM_W'(MAX_PERIOD);

  logic [CNT_W-1:0]  highCnt, lowCnt;
  logic [SUM_W-1:0]  periodLen;
  logic [PROD_W-1:0] highScaled, loBound, hiBound;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
      lowCnt  <= '0;
    end else if (strobe.rise) begin
      highCnt <= CNT_W'(1);
      lowCnt  <= '0;
    end else if (strobe.fall) begin
      lowCnt  <= CNT_W'(1);
    end else if (strobe.high) begin
      if (highCnt != CNT_MAX) highCnt <= highCnt + CNT_W'(1);
    end else begin
      if (lowCnt != CNT_MAX) lowCnt <= lowCnt + CNT_W'(1);
    end
  end

  always_comb begin
    periodLen  = SUM_W'(highCnt) + SUM_W'(lowCnt);
    highScaled = PROD_W'(highCnt)   * PROD_W'(DUTY_SCALE);
    loBound    = PROD_W'(periodLen) * PROD_W'(LO_NUM);
    hiBound    = PROD_W'(periodLen) * PROD_W'(HI_NUM);
    verdict.done    = strobe.rise;
    verdict.dutyOk  = (highScaled >= loBound) && (highScaled <= hiBound);
    verdict.overrun = periodLen > LEN_LIMIT;
  end

  // R9
  high_sat_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (highCnt == CNT_MAX && strobe.high && !strobe.rise) |=> highCnt == CNT_MAX);

  // R9
  low_sat_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (lowCnt == CNT_MAX && !strobe.high && !strobe.rise) |=> lowCnt == CNT_MAX);

  // R2
  rise_restart_chk: assert property (@(posedge refClk) disable iff (!rstN)
    strobe.rise |=> (lowCnt == '0 && highCnt == CNT_W'(1)));

endmodule

// File: rtl/clkw_ctrl.sv
module clkw_ctrl
  import clkw_pkg::*;
#(
  parameter int GOOD_NEED = 2
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        lvl,
  input  verdict_t    verdict,
  output edgeStrobe_t strobe,
  output logic        clkFail,
  output logic        regOff,
  output logic        clkPresent
);

  localparam int RUN_W = $clog2(GOOD_NEED + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(GOOD_NEED);

  logic             prevLvl;
  logic             primed;
  logic             slowLatch, dutyLatch;
  logic [RUN_W-1:0] goodRun;
  logic             judgedGood, judgedBad;

  always_comb begin
    strobe.rise = lvl && !prevLvl;
    strobe.fall = !lvl && prevLvl;
    strobe.high = lvl;
    judgedGood  = verdict.done && primed && verdict.dutyOk && !verdict.overrun;
    judgedBad   = verdict.done && primed && !(verdict.dutyOk && !verdict.overrun);
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      prevLvl   <= 1'b0;
      primed    <= 1'b0;
      slowLatch <= 1'b1;
      dutyLatch <= 1'b0;
      goodRun   <= '0;
    end else begin
      prevLvl <= lvl;
      if (strobe.rise) primed <= 1'b1;
      if (judgedGood) begin
        if (goodRun != RUN_TOP) goodRun <= goodRun + RUN_W'(1);
        if (goodRun >= RUN_TOP - RUN_W'(1)) begin
          slowLatch <= 1'b0;
          dutyLatch <= 1'b0;
        end
      end else if (judgedBad) begin
        goodRun <= '0;
        if (verdict.overrun) slowLatch <= 1'b1;
        else                 dutyLatch <= 1'b1;
      end else if (verdict.overrun) begin
        goodRun   <= '0;
        slowLatch <= 1'b1;
      end
    end
  end

  assign clkFail    = slowLatch || dutyLatch;
  assign regOff     = slowLatch;
  assign clkPresent = primed && !verdict.overrun;

  // R3 and R4
  duty_bad_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (verdict.done && primed && !verdict.dutyOk) |=> clkFail);

  // R5
  slow_period_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (verdict.done && primed && verdict.overrun) |=> (regOff && clkFail));

  // R6
  stall_chk: assert property (@(posedge refClk) disable iff (!rstN)
    verdict.overrun |=> (regOff && clkFail));

  // R7
  recover_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(clkFail) |-> $past(judgedGood));

  // R7
  flags_together_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(regOff) |-> !clkFail);

  // R8
  present_after_rise_chk: assert property (@(posedge refClk) disable iff (!rstN)
    strobe.rise |=> clkPresent);

endmodule

// File: rtl/extclk_watchdog.sv
module extclk_watchdog #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int MAX_PERIOD  = 80,
  parameter int DUTY_SCALE  = 20,
  parameter int LO_NUM      = 9,
  parameter int HI_NUM      = 11,
  parameter int GOOD_NEED   = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic extClk,
  output logic clkFail,
  output logic regOff,
  output logic clkPresent
);

  import clkw_pkg::*;

  logic        syncLvl;
  edgeStrobe_t strobe;
  verdict_t    verdict;

  clkw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .refClk  (refClk),
    .rstN    (rstN),
    .asyncIn (extClk),
    .syncOut (syncLvl)
  );

  clkw_ctrl #(.GOOD_NEED(GOOD_NEED)) u_ctrl (
    .refClk     (refClk),
    .rstN       (rstN),
    .lvl        (syncLvl),
    .verdict    (verdict),
    .strobe     (strobe),
    .clkFail    (clkFail),
    .regOff     (regOff),
    .clkPresent (clkPresent)
  );

  clkw_datapath #(
    .CNT_W      (CNT_W),
    .MAX_PERIOD (MAX_PERIOD),
    .DUTY_SCALE (DUTY_SCALE),
    .LO_NUM     (LO_NUM),
    .HI_NUM     (HI_NUM)
  ) u_dp (
    .refClk  (refClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .verdict (verdict)
  );

endmodule

// File: tb/sim_extclk_watchdog.sv
module sim_extclk_watchdog;

  logic refClk = 1'b0;
  logic rstN   = 1'b0;
  logic extClk = 1'b0;
  logic clkFail, regOff, clkPresent;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  // bench model state
  bit mSlow = 1'b1;
  bit mDuty = 1'b0;
  int mRun  = 0;
  bit havePrev = 1'b0;
  int prevH = 0;
  int prevL = 0;

  extclk_watchdog u0 (
    .refClk     (refClk),
    .rstN       (rstN),
    .extClk     (extClk),
    .clkFail    (clkFail),
    .regOff     (regOff),
    .clkPresent (clkPresent)
  );

  always #4 refClk = ~refClk;  // 125 MHz

  function automatic bit dutyInWindow(int h, int l);
    int p = h + l;
    return (20 * h >= 9 * p) && (20 * h <= 11 * p);
  endfunction

  task automatic check(string tag, string what, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic judgePrev();
    if (!havePrev) return;
    if (prevH + prevL > 80) begin          // R5
      mSlow = 1'b1; mRun = 0;
    end else if (!dutyInWindow(prevH, prevL)) begin  // R3 / R4
      mDuty = 1'b1; mRun = 0;
    end else begin                         // R7
      mRun++;
      if (mRun >= 2) begin mSlow = 1'b0; mDuty = 1'b0; end
    end
  endtask

  // Called right after a falling reference edge. Drives one full period.
  task automatic runPeriod(int h, int l, string tag);
    extClk = 1'b1;
    judgePrev();
    repeat (6) @(negedge refClk);
    check(tag, "clkFail", clkFail, mSlow | mDuty);
    check(tag, "regOff", regOff, mSlow);
    check("R8", "clkPresent", clkPresent, 1'b1);
    repeat (h - 6) @(negedge refClk);
    extClk = 1'b0;
    repeat (l) @(negedge refClk);
    prevH = h; prevL = l; havePrev = 1'b1;
  endtask

  task automatic stopLow(int n, string tag);
    repeat (n) @(negedge refClk);
    prevL += n;
    if (prevH + prevL > 80) begin mSlow = 1'b1; mRun = 0; end
    check(tag, "clkFail", clkFail, mSlow | mDuty);
    check(tag, "regOff", regOff, mSlow);
    check(tag, "clkPresent", clkPresent, !(prevH + prevL > 80));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge refClk);
    // R1: reset state
    check("R1", "clkFail", clkFail, 1'b1);
    check("R1", "regOff", regOff, 1'b1);
    check("R1", "clkPresent", clkPresent, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge refClk);
    check("R1", "clkFail after release", clkFail, 1'b1);
    check("R1", "clkPresent after release", clkPresent, 1'b0);

    // R7: start-up recovery with nominal clock
    for (int i = 0; i < 4; i++) runPeriod(16, 16, "R7");
    // R2 boundaries around 45 % and 55 %
    runPeriod(15, 17, "R2");
    runPeriod(14, 18, "R3");
    runPeriod(16, 16, "R3");   // sees the low-duty period: fail, regOff stays 0
    runPeriod(16, 16, "R7");
    runPeriod(17, 15, "R2");
    runPeriod(18, 14, "R4");
    runPeriod(16, 16, "R4");
    runPeriod(16, 16, "R7");
    runPeriod(16, 16, "R7");
    // R2 / R5 period limit
    runPeriod(40, 40, "R2");
    runPeriod(41, 40, "R5");
    runPeriod(16, 16, "R5");
    runPeriod(16, 16, "R7");
    runPeriod(16, 16, "R7");
    // R6 stall, R9 saturation
    runPeriod(16, 16, "R6");
    stopLow(150, "R6");
    stopLow(300, "R9");
    for (int i = 0; i < 4; i++) runPeriod(16, 16, "R7");
    // R7 interrupted recovery
    runPeriod(14, 18, "R7");
    runPeriod(16, 16, "R7");
    runPeriod(18, 14, "R7");
    runPeriod(16, 16, "R7");
    runPeriod(16, 16, "R7");
    runPeriod(16, 16, "R7");
    runPeriod(16, 16, "R7");

    // constrained random periods
    for (int i = 0; i < 60; i++) begin
      int p, h;
      p = 20 + int'($urandom % 81);
      if (p >= 79 && p <= 82) p = 60;
      h = (p * (30 + int'($urandom % 41))) / 100;
      if (h < 8) h = 8;
      if (h > p - 4) h = p - 4;
      runPeriod(h, p - h, "R2");
    end
    runPeriod(16, 16, "R2");
    stopLow(120, "R6");
    finishRun();
  end

endmodule